// File: doc/BRIEF.md
# Vector Floating-Point Class Tester

This block takes a 128-bit vector of IEEE-754 values and a 32-bit instruction word, and reports for each lane whether the value belongs to any of the classes that the instruction selects. A mode input chooses how the vector is split. In double mode it is two 64-bit lanes. In single mode it is four 32-bit lanes. The answer for each lane is a saturated flag as wide as the lane: all ones when the lane matches and all zeros when it does not.

The selection is a 7-bit class mask whose bits are spread over non-contiguous positions of the instruction word. Each lane is sorted into one of five classes from its exponent and fraction fields: NaN, infinity, zero, subnormal or normal. For infinity, zero and subnormal values the sign of the lane picks one of two mask bits. NaN has a single mask bit that ignores the sign. A normal value never matches.

The block is one pipeline stage. Inputs are taken on a cycle with `in_valid` high, and the result appears on the next cycle together with `out_valid`.

Top module: `fp_class_tester`

## Requirements
- R1: With `in_dp` = 1 the vector is two independent 64-bit lanes (lane 0 = bits 63:0). With `in_dp` = 0 it is four independent 32-bit lanes (lane 0 = bits 31:0). Each lane's result fills exactly that lane's bits of `out_vec`.
- R2: The class mask is formed from the instruction word, with bit 0 as the LSB. Mask bits 4..0 are instruction bits 20..16, mask bit 5 is instruction bit 2, and mask bit 6 is instruction bit 6. No other instruction bit affects the result.
- R3: A NaN lane (exponent all ones, fraction nonzero, quiet or signaling) matches when mask bit 6 is set, for either sign.
- R4: An infinite lane (exponent all ones, fraction zero) is tested against mask bit 5 when its sign bit (the lane MSB) is 0 and against mask bit 4 when the sign bit is 1.
- R5: A zero lane (exponent zero, fraction zero) is tested against mask bit 3 when positive and against mask bit 2 when negative.
- R6: A subnormal lane (exponent zero, fraction nonzero) is tested against mask bit 1 when positive and against mask bit 0 when negative.
- R7: A normal lane never matches. A matching lane yields all ones over the lane width and a non-matching lane yields all zeros, so an all-zero mask gives an all-zero result.
- R8: When `in_valid` is high at a rising clock edge, the result is on `out_vec` and `out_valid` is high right after that edge. `out_valid` is low after an edge where `in_valid` was low, and `out_vec` then keeps its previous value.
- R9: `rst_n` is a synchronous active-low reset. At an edge where it is low, `out_valid` and `out_vec` are cleared to zero, whatever `in_valid` is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Capture the inputs on this edge |
| in_dp | input | 1 | 1 = two 64-bit lanes, 0 = four 32-bit lanes |
| in_insn | input | 32 | Instruction word carrying the class mask |
| in_vec | input | 128 | Vector of floating-point values to test |
| out_valid | output | 1 | Result on `out_vec` is new this cycle |
| out_vec | output | 128 | Per-lane all-ones or all-zeros result |

## Verification
Every result is due one clock edge after the stimulus is presented. The bench drives its inputs on a falling edge and lowers `in_valid` on the next falling edge. It reads `out_vec` and `out_valid` at that second falling edge, half a cycle after the capturing rising edge. The hold and reset checks each advance exactly one further edge before sampling. In that cycle `out_vec` must still show the earlier value, or must be zero after a reset.

// File: rtl/fpct_pkg.sv
// Package: shared widths and the lane class type for the class tester.
// Assumes a 7-bit class mask. Bit indices below are the behavioural map
// from (class, sign) to mask position.
package fpct_pkg;

    localparam int MASK_W = 7;

    // Mask bit positions, tied to behaviour (sign-qualified pairs).
    localparam int MB_SUB_NEG  = 0;
    localparam int MB_SUB_POS  = 1;
    localparam int MB_ZERO_NEG = 2;
    localparam int MB_ZERO_POS = 3;
    localparam int MB_INF_NEG  = 4;
    localparam int MB_INF_POS  = 5;
    localparam int MB_NAN      = 6;

    typedef logic [MASK_W-1:0] cls_mask_t;

    typedef enum logic [2:0] {
        CLS_NORMAL  = 3'd0,
        CLS_SUBNORM = 3'd1,
        CLS_ZERO    = 3'd2,
        CLS_INF     = 3'd3,
        CLS_NAN     = 3'd4
    } fp_cls_e;

endpackage

// File: rtl/fpct_mask_extract.sv
// Module: fpct_mask_extract
// Gathers the scattered class-mask bits out of an instruction word.
// Assumes the low field is contiguous and the two upper bits are
// single positions. All positions are parameters.
module fpct_mask_extract
    import fpct_pkg::*;
#(
    parameter int INSN_W   = 32,
    parameter int LO_POS   = 16,
    parameter int LO_W     = 5,
    parameter int B5_POS   = 2,
    parameter int B6_POS   = 6
) (
    input  logic [INSN_W-1:0] insn,
    output cls_mask_t         mask
);

    localparam int LO_TOP = LO_POS + LO_W - 1;

    // Route each instruction bit to its mask slot.
    always_comb begin
        mask             = '0;
        mask[LO_W-1:0]   = insn[LO_TOP:LO_POS];
        mask[MB_INF_POS] = insn[B5_POS];
        mask[MB_NAN]     = insn[B6_POS];
    end

endmodule

// File: rtl/fpct_lane_classify.sv
// Module: fpct_lane_classify
// Sorts one IEEE-754 value of a given exponent/fraction width into
// NaN, infinity, zero, subnormal or normal, and reports its sign.
// Assumes the layout sign | exponent | fraction, MSB first.
module fpct_lane_classify
    import fpct_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52
) (
    input  logic [EXP_W+FRAC_W:0] lane,
    output fp_cls_e               cls,
    output logic                  neg
);

    localparam int LANE_W = EXP_W + FRAC_W + 1;

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic              exp_max;
    logic              exp_min;
    logic              frac_nz;

    // Split the lane into its fields.
    always_comb begin
        neg    = lane[LANE_W-1];
        exp_f  = lane[LANE_W-2:FRAC_W];
        frac_f = lane[FRAC_W-1:0];
    end

    // Field predicates.
    always_comb begin
        exp_max = &exp_f;
        exp_min = ~|exp_f;
        frac_nz = |frac_f;
    end

    // Class selection; the field tests are mutually exclusive.
    always_comb begin
        if (exp_max && frac_nz)       cls = CLS_NAN;
        else if (exp_max)             cls = CLS_INF;
        else if (exp_min && !frac_nz) cls = CLS_ZERO;
        else if (exp_min)             cls = CLS_SUBNORM;
        else                          cls = CLS_NORMAL;
    end

endmodule

// File: rtl/fpct_lane_match.sv
// Module: fpct_lane_match
// Looks up one lane's class and sign in the class mask and drives a
// saturated result as wide as the lane.
// Assumes the mask positions from fpct_pkg.
module fpct_lane_match
    import fpct_pkg::*;
#(
    parameter int LANE_W = 64
) (
    input  fp_cls_e           cls,
    input  logic              neg,
    input  cls_mask_t         mask,
    output logic [LANE_W-1:0] res
);

    logic hit;

    // Pick the mask bit that this class and sign select.
    always_comb begin
        unique case (cls)
            CLS_NAN:     hit = mask[MB_NAN];
            CLS_INF:     hit = neg ? mask[MB_INF_NEG]  : mask[MB_INF_POS];
            CLS_ZERO:    hit = neg ? mask[MB_ZERO_NEG] : mask[MB_ZERO_POS];
            CLS_SUBNORM: hit = neg ? mask[MB_SUB_NEG]  : mask[MB_SUB_POS];
            default:     hit = 1'b0;
        endcase
    end

    // Saturate the flag over the lane.
    always_comb res = {LANE_W{hit}};

endmodule

// File: rtl/fp_class_tester.sv
// Module: fp_class_tester (top)
// Tests a vector of double or single values against a class mask drawn
// from an instruction word, one saturated flag per lane, registered
// once. Both lane splits are evaluated in parallel and the mode picks one.
// Assumes VEC_W is a multiple of both lane widths.
module fp_class_tester
    import fpct_pkg::*;
#(
    parameter int VEC_W     = 128,
    parameter int INSN_W    = 32,
    parameter int DP_EXP_W  = 11,
    parameter int DP_FRAC_W = 52,
    parameter int SP_EXP_W  = 8,
    parameter int SP_FRAC_W = 23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_dp,
    input  logic [INSN_W-1:0] in_insn,
    input  logic [VEC_W-1:0]  in_vec,
    output logic              out_valid,
    output logic [VEC_W-1:0]  out_vec
);

    localparam int DP_W     = DP_EXP_W + DP_FRAC_W + 1;
    localparam int SP_W     = SP_EXP_W + SP_FRAC_W + 1;
    localparam int DP_LANES = VEC_W / DP_W;
    localparam int SP_LANES = VEC_W / SP_W;

    cls_mask_t          mask;
    logic [VEC_W-1:0]   dp_res;
    logic [VEC_W-1:0]   sp_res;
    logic [VEC_W-1:0]   sel_res;

    fpct_mask_extract #(
        .INSN_W (INSN_W),
        .LO_POS (16),
        .LO_W   (5),
        .B5_POS (2),
        .B6_POS (6)
    ) u_mask (
        .insn (in_insn),
        .mask (mask)
    );

    // Double-width lanes.
    for (genvar g = 0; g < DP_LANES; g++) begin : g_dp
        fp_cls_e cls;
        logic    neg;

        fpct_lane_classify #(
            .EXP_W  (DP_EXP_W),
            .FRAC_W (DP_FRAC_W)
        ) u_cls (
            .lane (in_vec[g*DP_W +: DP_W]),
            .cls  (cls),
            .neg  (neg)
        );

        fpct_lane_match #(
            .LANE_W (DP_W)
        ) u_match (
            .cls  (cls),
            .neg  (neg),
            .mask (mask),
            .res  (dp_res[g*DP_W +: DP_W])
        );
    end

    // Single-width lanes.
    for (genvar g = 0; g < SP_LANES; g++) begin : g_sp
        fp_cls_e cls;
        logic    neg;

        fpct_lane_classify #(
            .EXP_W  (SP_EXP_W),
            .FRAC_W (SP_FRAC_W)
        ) u_cls (
            .lane (in_vec[g*SP_W +: SP_W]),
            .cls  (cls),
            .neg  (neg)
        );

        fpct_lane_match #(
            .LANE_W (SP_W)
        ) u_match (
            .cls  (cls),
            .neg  (neg),
            .mask (mask),
            .res  (sp_res[g*SP_W +: SP_W])
        );
    end

    // Choose the lane split that the mode asks for.
    always_comb sel_res = in_dp ? dp_res : sp_res;

    // Output stage: clear on reset, load on valid, else hold data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_vec   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_vec <= sel_res;
        end
    end

endmodule

// File: rtl/fpct_checker.sv
// Module: fpct_checker
// Temporal properties of fp_class_tester, attached by bind below.
// Assumes the default 128-bit vector and 32-bit instruction word.
module fpct_checker (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic         in_dp,
    input logic [31:0]  in_insn,
    input logic [127:0] in_vec,
    input logic         out_valid,
    input logic [127:0] out_vec
);

    logic mask_empty;
    logic sp0_nan;

    // Helper terms decoded from the ports.
    always_comb begin
        mask_empty = (in_insn[20:16] == 5'd0) && !in_insn[2] && !in_insn[6];
        sp0_nan    = (in_vec[30:23] == 8'hFF) && (in_vec[22:0] != 23'd0);
    end

    p_valid_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(in_valid)));

    p_hold_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(in_valid)) |-> $stable(out_vec));

    p_reset_clear_r9: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_vec == 128'd0));

    p_empty_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mask_empty) |=> (out_vec == 128'd0));

    p_dp_lane_span_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_dp) |=> (out_vec[63:32] == out_vec[31:0] &&
                                 out_vec[127:96] == out_vec[95:64]));

    p_sp_nan_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_dp && in_insn[6] && sp0_nan) |=> (out_vec[31:0] == 32'hFFFF_FFFF));

    p_saturated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_vec[31:0]   == 32'd0 || out_vec[31:0]   == 32'hFFFF_FFFF) &&
                       (out_vec[63:32]  == 32'd0 || out_vec[63:32]  == 32'hFFFF_FFFF) &&
                       (out_vec[95:64]  == 32'd0 || out_vec[95:64]  == 32'hFFFF_FFFF) &&
                       (out_vec[127:96] == 32'd0 || out_vec[127:96] == 32'hFFFF_FFFF)));

endmodule

bind fp_class_tester fpct_checker u_chk (.*);

// File: tb/fp_class_tester_tb.sv
module fp_class_tester_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_dp = 1'b0;
    logic [31:0]  in_insn = '0;
    logic [127:0] in_vec = '0;
    logic         out_valid;
    logic [127:0] out_vec;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2 clk = ~clk;   // 250 MHz

    fp_class_tester u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_dp     (in_dp),
        .in_insn   (in_insn),
        .in_vec    (in_vec),
        .out_valid (out_valid),
        .out_vec   (out_vec)
    );

    typedef struct packed {
        logic         dp;
        logic [6:0]   m;
        logic [127:0] v;
        logic [127:0] e;
    } tv_t;

    localparam int NTV = 10;
    localparam tv_t TV [NTV] = '{
        '{1'b0, 7'h40, 128'h7FC00000_FF800001_7F800000_3F800000, 128'hFFFFFFFF_FFFFFFFF_00000000_00000000},
        '{1'b0, 7'h20, 128'h7F800000_FF800000_00000000_7FC00000, 128'hFFFFFFFF_00000000_00000000_00000000},
        '{1'b0, 7'h14, 128'hFF800000_7F800000_80000000_00000000, 128'hFFFFFFFF_00000000_FFFFFFFF_00000000},
        '{1'b0, 7'h03, 128'h00000001_807FFFFF_3F800000_BF800000, 128'hFFFFFFFF_FFFFFFFF_00000000_00000000},
        '{1'b1, 7'h7F, 128'hBFF0000000000000_0000000000000000, 128'h0000000000000000_FFFFFFFFFFFFFFFF},
        '{1'b1, 7'h08, 128'h0000000000000000_8000000000000000, 128'hFFFFFFFFFFFFFFFF_0000000000000000},
        '{1'b1, 7'h02, 128'h0000000000000001_800FFFFFFFFFFFFF, 128'hFFFFFFFFFFFFFFFF_0000000000000000},
        '{1'b1, 7'h30, 128'hFFF0000000000000_7FF8000000000000, 128'hFFFFFFFFFFFFFFFF_0000000000000000},
        '{1'b0, 7'h08, 128'h00000000_00000000_80000000_00000000, 128'hFFFFFFFF_FFFFFFFF_00000000_FFFFFFFF},
        '{1'b1, 7'h08, 128'h00000000_00000000_80000000_00000000, 128'hFFFFFFFFFFFFFFFF_0000000000000000}
    };

    // One value per class and sign, single then double format.
    localparam logic [31:0] SPV [10] = '{
        32'h7FC00000, 32'hFF800001, 32'h7F800000, 32'hFF800000, 32'h00000000,
        32'h80000000, 32'h00000001, 32'h807FFFFF, 32'h3F800000, 32'hBF800000
    };
    localparam logic [63:0] DPV [10] = '{
        64'h7FF8000000000000, 64'hFFF0000000000001, 64'h7FF0000000000000,
        64'hFFF0000000000000, 64'h0000000000000000, 64'h8000000000000000,
        64'h0000000000000001, 64'h800FFFFFFFFFFFFF, 64'h3FF0000000000000,
        64'hBFF0000000000000
    };

    // Place the 7 mask bits at their instruction positions; all other bits set (R2).
    function automatic logic [31:0] mk_insn(input logic [6:0] m);
        logic [31:0] w;
        w        = 32'hFFE0_FFBB;
        w[20:16] = m[4:0];
        w[2]     = m[5];
        w[6]     = m[6];
        return w;
    endfunction

    // Reference model for one lane from R3..R7.
    function automatic logic ref_hit(input logic [63:0] v, input int ew, input int fw,
                                     input logic [6:0] m);
        logic [63:0] ex, fr;
        logic        s;
        ex = (v >> fw) & ((64'd1 << ew) - 64'd1);
        fr = v & ((64'd1 << fw) - 64'd1);
        s  = v[ew + fw];
        if (ex == ((64'd1 << ew) - 64'd1)) return (fr != 0) ? m[6] : (s ? m[4] : m[5]);
        if (ex == 64'd0)                   return (fr == 0) ? (s ? m[2] : m[3]) : (s ? m[0] : m[1]);
        return 1'b0;
    endfunction

    function automatic logic [127:0] ref_vec(input logic dp, input logic [6:0] m,
                                             input logic [127:0] v);
        logic [127:0] r = '0;
        if (dp) begin
            for (int l = 0; l < 2; l++)
                r[l*64 +: 64] = {64{ref_hit(v[l*64 +: 64], 11, 52, m)}};
        end else begin
            for (int l = 0; l < 4; l++)
                r[l*32 +: 32] = {32{ref_hit({32'd0, v[l*32 +: 32]}, 8, 23, m)}};
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Present one stimulus for one edge; return at the sampling point.
    task automatic apply(input logic dp, input logic [31:0] insn, input logic [127:0] v);
        @(negedge clk);
        in_valid = 1'b1;
        in_dp    = dp;
        in_insn  = insn;
        in_vec   = v;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        logic [127:0] held;
        logic [6:0]   masks [9];
        for (int k = 0; k < 7; k++) masks[k] = 7'(1 << k);
        masks[7] = 7'h7F;
        masks[8] = 7'h00;

        // Reset state, with in_valid high during reset (R9).
        in_valid = 1'b1;
        in_vec   = {4{32'h7FC00000}};
        in_insn  = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        check("R9 reset out_valid", {127'd0, out_valid}, 128'd0);
        check("R9 reset out_vec", out_vec, 128'd0);
        in_valid = 1'b0;
        rst_n    = 1'b1;

        // Table walk (R1, R3..R7).
        for (int i = 0; i < NTV; i++) begin
            apply(TV[i].dp, mk_insn(TV[i].m), TV[i].v);
            check("R1/R3-R7 table", out_vec, TV[i].e);
            check("R8 out_valid after capture", {127'd0, out_valid}, 128'd1);
        end

        // Sweep: each single-bit mask, all-ones and empty mask, both modes.
        for (int mi = 0; mi < 9; mi++) begin
            for (int g = 0; g < 10; g++) begin
                logic [127:0] v;
                for (int l = 0; l < 4; l++) v[l*32 +: 32] = SPV[(g + l*3) % 10];
                apply(1'b0, mk_insn(masks[mi]), v);
                check("R1 R3 R4 R5 R6 R7 single sweep", out_vec, ref_vec(1'b0, masks[mi], v));
                v = {DPV[(g + 7) % 10], DPV[g]};
                apply(1'b1, mk_insn(masks[mi]), v);
                check("R1 R3 R4 R5 R6 R7 double sweep", out_vec, ref_vec(1'b1, masks[mi], v));
            end
        end

        // R2: only mask bit 5 set by instruction bit 2, all others zero.
        apply(1'b0, 32'h0000_0004, {SPV[2], SPV[3], SPV[0], SPV[4]});
        check("R2 bit2 selects positive infinity", out_vec, {32'hFFFFFFFF, 96'd0});
        // R2: every non-mask bit set, mask bits clear: nothing matches.
        apply(1'b1, 32'hFFE0_FFBB, {DPV[0], DPV[2]});
        check("R2 non-mask bits ignored", out_vec, 128'd0);

        // R8: hold when in_valid is low.
        apply(1'b0, mk_insn(7'h7F), {SPV[0], SPV[8], SPV[4], SPV[9]});
        held = out_vec;
        check("R8 before hold", held, {32'hFFFFFFFF, 32'd0, 32'hFFFFFFFF, 32'd0});
        in_insn = mk_insn(7'h00);
        in_vec  = 128'd0;
        @(negedge clk);
        check("R8 hold out_vec", out_vec, held);
        check("R8 out_valid low", {127'd0, out_valid}, 128'd0);

        // R9: reset mid-run clears a nonzero result.
        apply(1'b1, mk_insn(7'h7F), {DPV[0], DPV[1]});
        check("R9 pre-reset value", out_vec, {128{1'b1}});
        rst_n    = 1'b0;
        in_valid = 1'b1;
        @(negedge clk);
        check("R9 mid-run reset out_vec", out_vec, 128'd0);
        check("R9 mid-run reset out_valid", {127'd0, out_valid}, 128'd0);
        in_valid = 1'b0;
        rst_n    = 1'b1;
        @(negedge clk);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule